// File: doc/BRIEF.md
# Single-Cycle 32-bit Integer Processor Core

This block is a 32-bit processor core that completes one instruction on every rising clock edge. It covers a small integer subset: five register-to-register operations, a word load, a word store, a branch on equal and an absolute jump. The core holds its own program counter, a 32-entry register file, an ALU, and two separate word-addressed arrays, one for instructions and one for data. Decoding happens in two levels. A main decoder turns the opcode into datapath controls and a 2-bit ALU class. A second decoder turns that class, together with the function field, into a 4-bit ALU operation.

Both arrays are filled through a narrow load port, normally while the core is held in reset. After reset is released, the core runs from address zero. Each cycle it shows, on trace outputs, the register write or the memory store it will commit at the next clock edge, and it also shows its current program counter. An environment follows execution through these outputs.

Top module: `sc_cpu`

## Requirements
- R1: While `rst_n` is low at a clock edge, the PC becomes 0 and all 32 registers become 0. During reset `wb_en` and `st_en` stay low.
- R2: Opcode 0 is R-type, with fields rs[25:21], rt[20:16], rd[15:11] and funct[5:0]. Funct 32 writes rs+rt to rd, funct 34 writes rs-rt, funct 36 writes rs AND rt, and funct 37 writes rs OR rt.
- R3: R-type funct 42 writes 1 to rd when rs is less than rt as signed 32-bit numbers, and writes 0 otherwise.
- R4: Opcode 35 (load) writes to rt the data word at index bits [DAW+1:2] of rs plus the sign-extended immediate in bits [15:0].
- R5: Opcode 43 (store) writes rt to the data word at that same index. `st_addr` shows the full computed byte address and `st_val` shows the stored value.
- R6: Opcode 4 (branch) compares rs with rt. When they are equal, the next PC is PC+4 plus the sign-extended immediate shifted left by 2. Otherwise the next PC is PC+4. A branch writes no register and no memory.
- R7: Opcode 2 (jump) sets the next PC to bits [31:28] of PC+4, then instruction bits [25:0], then two zero bits.
- R8: Register 0 always reads as 0. An instruction whose destination is register 0 leaves `wb_en` low and changes no state.
- R9: Any other opcode writes nothing and advances the PC by 4.
- R10: Exactly one instruction completes per cycle. The instruction is fetched from the word at index PC[IAW+1:2], so indices wrap modulo the array depth. Every instruction other than a taken branch or a jump advances the PC by 4.
- R11: When `ld_we` is high at a clock edge, `ld_data` is written to word `ld_idx`. The word goes to the data array if `ld_dmem` is 1 and to the instruction array if it is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; all state changes on the rising edge |
| rst_n | input | 1 | Synchronous active-low reset |
| ld_we | input | 1 | Array load strobe |
| ld_dmem | input | 1 | Load target: 1 selects the data array, 0 selects the instruction array |
| ld_idx | input | LDW | Word index for the load |
| ld_data | input | 32 | Word to load |
| pc_o | output | 32 | Current program counter |
| wb_en | output | 1 | A register write commits at the next edge |
| wb_idx | output | 5 | Destination register of that write |
| wb_val | output | 32 | Value of that write |
| st_en | output | 1 | A data store commits at the next edge |
| st_addr | output | 32 | Byte address of that store |
| st_val | output | 32 | Value of that store |

## Verification
A wrong register value stays hidden until an instruction reads it. It then shows up on `wb_val` or `st_val`, or as a wrong PC after a branch, in the very cycle that instruction executes. A decoding or PC-selection fault shows up on the same cycle as a trace mismatch or as a divergent `pc_o`. Because of this, the bench runs a lock-step arithmetic model and compares the PC and both trace ports on every cycle. It uses a directed program plus long pseudo-random instruction streams drawn densely from eight registers, so that values flow back into later instructions within a few cycles.

// File: rtl/sc_pkg.sv
// Shared types for the single-cycle core: opcodes, ALU codes, control word
// and the instruction field layout. Assumes 32-bit instructions and data.
package sc_pkg;
    localparam logic [5:0] OP_RTYPE = 6'd0;
    localparam logic [5:0] OP_JUMP  = 6'd2;
    localparam logic [5:0] OP_BEQ   = 6'd4;
    localparam logic [5:0] OP_LOAD  = 6'd35;
    localparam logic [5:0] OP_STORE = 6'd43;

    localparam logic [5:0] FN_ADD = 6'd32;
    localparam logic [5:0] FN_SUB = 6'd34;
    localparam logic [5:0] FN_AND = 6'd36;
    localparam logic [5:0] FN_OR  = 6'd37;
    localparam logic [5:0] FN_SLT = 6'd42;

    typedef enum logic [3:0] {
        ALU_AND = 4'b0000,
        ALU_OR  = 4'b0001,
        ALU_ADD = 4'b0010,
        ALU_SUB = 4'b0110,
        ALU_SLT = 4'b0111
    } alu_code_e;

    typedef enum logic [1:0] {
        CLS_ADD   = 2'b00,
        CLS_SUB   = 2'b01,
        CLS_FIELD = 2'b10
    } alu_class_e;

    typedef struct packed {
        logic       dst_rd;
        logic       b_imm;
        logic       wb_mem;
        logic       reg_wr;
        logic       mem_rd;
        logic       mem_wr;
        logic       branch;
        logic       jump;
        alu_class_e cls;
    } ctrl_t;

    typedef struct packed {
        logic [5:0] op;
        logic [4:0] rs;
        logic [4:0] rt;
        logic [4:0] rd;
        logic [4:0] shamt;
        logic [5:0] funct;
    } ifields_t;
endpackage

// File: rtl/sc_main_ctrl.sv
// Main decoder: maps the opcode onto datapath controls and an ALU class.
// Assumes unknown opcodes must behave as no-ops (all enables low).
module sc_main_ctrl
    import sc_pkg::*;
(
    input  logic [5:0] op,
    output ctrl_t      ctl
);
    // Opcode to control word; don't-care fields are tied low.
    always_comb begin
        ctl = '0;
        ctl.cls = CLS_ADD;
        case (op)
            OP_RTYPE: begin
                ctl.dst_rd = 1'b1;
                ctl.reg_wr = 1'b1;
                ctl.cls    = CLS_FIELD;
            end
            OP_LOAD: begin
                ctl.b_imm  = 1'b1;
                ctl.wb_mem = 1'b1;
                ctl.reg_wr = 1'b1;
                ctl.mem_rd = 1'b1;
            end
            OP_STORE: begin
                ctl.b_imm  = 1'b1;
                ctl.mem_wr = 1'b1;
            end
            OP_BEQ: begin
                ctl.branch = 1'b1;
                ctl.cls    = CLS_SUB;
            end
            OP_JUMP: ctl.jump = 1'b1;
            default: ;
        endcase
    end
endmodule

// File: rtl/sc_alu_ctrl.sv
// Second-level decoder: ALU class plus function field to ALU operation.
// Assumes unlisted function codes fall back to addition.
module sc_alu_ctrl
    import sc_pkg::*;
(
    input  alu_class_e cls,
    input  logic [5:0] funct,
    output alu_code_e  code
);
    // Class selects a fixed op, or defers to the function field.
    always_comb begin
        case (cls)
            CLS_SUB:   code = ALU_SUB;
            CLS_FIELD: begin
                case (funct)
                    FN_SUB:  code = ALU_SUB;
                    FN_AND:  code = ALU_AND;
                    FN_OR:   code = ALU_OR;
                    FN_SLT:  code = ALU_SLT;
                    default: code = ALU_ADD;
                endcase
            end
            default:   code = ALU_ADD;
        endcase
    end
endmodule

// File: rtl/sc_alu.sv
// 32-bit ALU with a zero flag. Set-less-than compares as signed numbers.
module sc_alu
    import sc_pkg::*;
#(
    parameter int W = 32
) (
    input  logic [W-1:0] a,
    input  logic [W-1:0] b,
    input  alu_code_e    code,
    output logic [W-1:0] y,
    output logic         zero
);
    // Operation select.
    always_comb begin
        case (code)
            ALU_AND: y = a & b;
            ALU_OR:  y = a | b;
            ALU_SUB: y = a - b;
            ALU_SLT: y = {{(W-1){1'b0}}, ($signed(a) < $signed(b))};
            default: y = a + b;
        endcase
    end

    assign zero = (y == '0);
endmodule

// File: rtl/sc_regfile.sv
// Register file: NREG x W, NRD combinational read ports, one write port.
// Entry 0 reads as zero and is never written; all entries clear on reset.
module sc_regfile #(
    parameter int W    = 32,
    parameter int NREG = 32,
    parameter int NRD  = 2,
    localparam int RAW = $clog2(NREG)
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic [NRD-1:0][RAW-1:0] ra,
    output logic [NRD-1:0][W-1:0]   rv,
    input  logic                we,
    input  logic [RAW-1:0]      wa,
    input  logic [W-1:0]        wv
);
    logic [W-1:0] regs [NREG];

    // Clear on reset, otherwise commit the write unless it targets entry 0.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < NREG; i++) regs[i] <= '0;
        end else if (we && wa != '0) begin
            regs[wa] <= wv;
        end
    end

    for (genvar p = 0; p < NRD; p++) begin : g_rd
        assign rv[p] = (ra[p] == '0) ? '0 : regs[ra[p]];
    end
endmodule

// File: rtl/sc_cpu.sv
// Single-cycle core top: PC, instruction and data arrays, decoders,
// register file and ALU. Arrays are loaded through the ld_* port.
// Assumes word indices wrap modulo array depth.
module sc_cpu
    import sc_pkg::*;
#(
    parameter int IMEM_WORDS = 64,
    parameter int DMEM_WORDS = 64,
    localparam int IAW = $clog2(IMEM_WORDS),
    localparam int DAW = $clog2(DMEM_WORDS),
    localparam int LDW = (IAW > DAW) ? IAW : DAW
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           ld_we,
    input  logic           ld_dmem,
    input  logic [LDW-1:0] ld_idx,
    input  logic [31:0]    ld_data,
    output logic [31:0]    pc_o,
    output logic           wb_en,
    output logic [4:0]     wb_idx,
    output logic [31:0]    wb_val,
    output logic           st_en,
    output logic [31:0]    st_addr,
    output logic [31:0]    st_val
);
    logic [31:0] imem [IMEM_WORDS];
    logic [31:0] dmem [DMEM_WORDS];
    logic [31:0] pc_q, pc_seq, pc_next, br_tgt, jmp_tgt, instr, imm_x;
    ifields_t    f;
    ctrl_t       ctl;
    alu_code_e   acode;
    logic [1:0][4:0]  ra;
    logic [1:0][31:0] rv;
    logic [31:0] rs_val, rt_val, alu_b, alu_y, ld_word;
    logic [4:0]  rs_idx;
    logic        alu_zero, take_br, is_branch, is_jump;

    assign instr = imem[pc_q[IAW+1:2]];
    assign f     = ifields_t'(instr);
    assign imm_x = {{16{instr[15]}}, instr[15:0]};

    sc_main_ctrl u_main (.op(f.op), .ctl(ctl));
    sc_alu_ctrl  u_actl (.cls(ctl.cls), .funct(f.funct), .code(acode));

    assign ra     = {f.rt, f.rs};
    assign rs_idx = f.rs;
    assign rs_val = rv[0];
    assign rt_val = rv[1];

    sc_regfile #(.W(32), .NREG(32), .NRD(2)) u_rf (
        .clk(clk), .rst_n(rst_n), .ra(ra), .rv(rv),
        .we(wb_en), .wa(wb_idx), .wv(wb_val)
    );

    assign alu_b = ctl.b_imm ? imm_x : rt_val;
    sc_alu #(.W(32)) u_alu (.a(rs_val), .b(alu_b), .code(acode), .y(alu_y), .zero(alu_zero));

    assign ld_word = ctl.mem_rd ? dmem[alu_y[DAW+1:2]] : '0;

    assign wb_idx  = ctl.dst_rd ? f.rd : f.rt;
    assign wb_val  = ctl.wb_mem ? ld_word : alu_y;
    assign wb_en   = rst_n && ctl.reg_wr && (wb_idx != 5'd0);
    assign st_en   = rst_n && ctl.mem_wr;
    assign st_addr = alu_y;
    assign st_val  = rt_val;

    assign is_branch = ctl.branch;
    assign is_jump   = ctl.jump;
    assign take_br   = ctl.branch && alu_zero;
    assign pc_seq    = pc_q + 32'd4;
    assign br_tgt    = pc_seq + {imm_x[29:0], 2'b00};
    assign jmp_tgt   = {pc_seq[31:28], instr[25:0], 2'b00};

    // Next-PC select: jump, taken branch, or sequential.
    always_comb begin
        if (ctl.jump)    pc_next = jmp_tgt;
        else if (take_br) pc_next = br_tgt;
        else             pc_next = pc_seq;
    end

    // Program counter register.
    always_ff @(posedge clk) begin
        if (!rst_n) pc_q <= '0;
        else        pc_q <= pc_next;
    end

    // Instruction array: written only through the load port.
    always_ff @(posedge clk) begin
        if (ld_we && !ld_dmem) imem[ld_idx[IAW-1:0]] <= ld_data;
    end

    // Data array: load port has priority over a store.
    always_ff @(posedge clk) begin
        if (ld_we && ld_dmem)  dmem[ld_idx[DAW-1:0]] <= ld_data;
        else if (st_en)        dmem[alu_y[DAW+1:2]]  <= rt_val;
    end

    assign pc_o = pc_q;
endmodule

// File: rtl/sc_cpu_chk.sv
// Property checker for sc_cpu, attached by bind. Observes the PC, trace
// ports and a few decoder/register-file signals.
module sc_cpu_chk (
    input logic        clk,
    input logic        rst_n,
    input logic [31:0] pc_o,
    input logic        wb_en,
    input logic        st_en,
    input logic        is_branch,
    input logic        is_jump,
    input logic        take_br,
    input logic [31:0] br_tgt,
    input logic [4:0]  rs_idx,
    input logic [31:0] rs_val
);
    p_pc_zero_r1: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_n) |-> pc_o == 32'd0);

    p_seq_step_r10: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && !$past(take_br) && !$past(is_jump)) |-> pc_o == $past(pc_o) + 32'd4);

    p_branch_tgt_r6: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $past(take_br)) |-> pc_o == $past(br_tgt));

    p_zero_reg_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (rs_idx == 5'd0) |-> rs_val == 32'd0);

    p_single_effect_r9: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({wb_en, st_en, is_branch, is_jump}));
endmodule

bind sc_cpu sc_cpu_chk chk_i (
    .clk(clk), .rst_n(rst_n), .pc_o(pc_o), .wb_en(wb_en), .st_en(st_en),
    .is_branch(is_branch), .is_jump(is_jump), .take_br(take_br),
    .br_tgt(br_tgt), .rs_idx(rs_idx), .rs_val(rs_val)
);

// File: tb/sc_cpu_tb_top.sv
// Lock-step bench: an arithmetic model of the instruction subset predicts
// the PC and trace outputs every cycle for directed and pseudo-random code.
module sc_cpu_tb_top;
    localparam int IW  = 64;
    localparam int DW  = 64;
    localparam int IAW = $clog2(IW);
    localparam int DAW = $clog2(DW);
    localparam int LDW = (IAW > DAW) ? IAW : DAW;

    logic           clk = 1'b0;
    logic           rst_n = 1'b0;
    logic           ld_we = 1'b0;
    logic           ld_dmem = 1'b0;
    logic [LDW-1:0] ld_idx = '0;
    logic [31:0]    ld_data = '0;
    logic [31:0]    pc_o, wb_val, st_addr, st_val;
    logic [4:0]     wb_idx;
    logic           wb_en, st_en;

    int n_checks = 0;
    int n_errors = 0;
    bit done = 1'b0;

    logic [31:0] m_im [IW];
    logic [31:0] m_dm [DW];
    logic [31:0] m_rf [32];
    logic [31:0] m_pc;
    logic [31:0] lcg;

    always #10 clk = ~clk;

    sc_cpu #(.IMEM_WORDS(IW), .DMEM_WORDS(DW)) dut_i (
        .clk(clk), .rst_n(rst_n), .ld_we(ld_we), .ld_dmem(ld_dmem),
        .ld_idx(ld_idx), .ld_data(ld_data), .pc_o(pc_o), .wb_en(wb_en),
        .wb_idx(wb_idx), .wb_val(wb_val), .st_en(st_en),
        .st_addr(st_addr), .st_val(st_val)
    );

    task automatic chk(input bit ok, input string tag, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (!ok) begin
            n_errors++;
            $display("FAIL %s %s: actual=%h expected=%h", tag, what, act, exp);
        end
    endtask

    function automatic logic [31:0] rnd();
        lcg = lcg * 32'd1664525 + 32'd1013904223;
        return lcg;
    endfunction

    function automatic logic [31:0] enc_r(input int rs, input int rt, input int rd, input logic [5:0] fn);
        return {6'd0, 5'(rs), 5'(rt), 5'(rd), 5'd0, fn};
    endfunction

    function automatic logic [31:0] enc_i(input logic [5:0] op, input int rs, input int rt, input logic [15:0] imm);
        return {op, 5'(rs), 5'(rt), imm};
    endfunction

    // Reset the core, load both arrays (R11), check the reset state (R1).
    task automatic start_phase();
        rst_n = 1'b0;
        for (int i = 0; i < IW; i++) begin
            @(negedge clk);
            ld_we = 1'b1; ld_dmem = 1'b0; ld_idx = LDW'(i); ld_data = m_im[i];
        end
        for (int i = 0; i < DW; i++) begin
            @(negedge clk);
            ld_we = 1'b1; ld_dmem = 1'b1; ld_idx = LDW'(i); ld_data = m_dm[i];
        end
        @(negedge clk);
        ld_we = 1'b0;
        @(negedge clk);
        #1;
        chk(pc_o == 32'd0, "R1", "pc in reset", pc_o, 32'd0);
        chk(wb_en == 1'b0, "R1", "wb_en in reset", 32'(wb_en), 32'd0);
        chk(st_en == 1'b0, "R1", "st_en in reset", 32'(st_en), 32'd0);
        for (int i = 0; i < 32; i++) m_rf[i] = '0;
        m_pc = '0;
        @(negedge clk);
        rst_n = 1'b1;
    endtask

    // Run n cycles, comparing every output against the model.
    task automatic run_cycles(input int n);
        for (int c = 0; c < n; c++) begin
            logic [31:0] ins, a, b, sx, seq, nxt, val, addr;
            logic [5:0]  op, fn;
            int          rs, rt, dst;
            bit          we, se;
            string       tag;
            #1;
            ins = m_im[m_pc[IAW+1:2]];
            op = ins[31:26]; fn = ins[5:0];
            rs = int'(ins[25:21]); rt = int'(ins[20:16]);
            a = m_rf[rs]; b = m_rf[rt];
            sx = {{16{ins[15]}}, ins[15:0]};
            seq = m_pc + 32'd4; nxt = seq;
            we = 0; se = 0; dst = 0; val = '0; addr = '0; tag = "R9";
            case (op)
                6'd0: begin
                    dst = int'(ins[15:11]); we = 1; tag = "R2";
                    case (fn)
                        6'd34: val = a - b;
                        6'd36: val = a & b;
                        6'd37: val = a | b;
                        6'd42: begin val = ($signed(a) < $signed(b)) ? 32'd1 : 32'd0; tag = "R3"; end
                        default: val = a + b;
                    endcase
                end
                6'd35: begin
                    addr = a + sx; dst = rt; we = 1; tag = "R4/R11";
                    val = m_dm[addr[DAW+1:2]];
                end
                6'd43: begin addr = a + sx; se = 1; tag = "R5"; end
                6'd4: begin
                    tag = "R6";
                    if (a == b) nxt = seq + {sx[29:0], 2'b00};
                end
                6'd2: begin tag = "R7"; nxt = {seq[31:28], ins[25:0], 2'b00}; end
                default: ;
            endcase
            if (we && dst == 0) begin we = 0; tag = "R8"; end
            chk(pc_o == m_pc, (op == 6'd4 || op == 6'd2) ? tag : "R10", "pc", pc_o, m_pc);
            chk(wb_en == we, tag, "wb_en", 32'(wb_en), 32'(we));
            if (we) begin
                chk(wb_idx == 5'(dst), tag, "wb_idx", 32'(wb_idx), 32'(dst));
                chk(wb_val == val, tag, "wb_val", wb_val, val);
                m_rf[dst] = val;
            end
            chk(st_en == se, tag, "st_en", 32'(st_en), 32'(se));
            if (se) begin
                chk(st_addr == addr, tag, "st_addr", st_addr, addr);
                chk(st_val == b, tag, "st_val", st_val, b);
                m_dm[addr[DAW+1:2]] = b;
            end
            m_pc = nxt;
            @(negedge clk);
        end
    endtask

    // Directed program: each operation, r0 write, branches, jump, no-op.
    task automatic directed();
        for (int i = 0; i < IW; i++) m_im[i] = {6'd63, 26'd0};
        for (int i = 0; i < DW; i++) m_dm[i] = 32'(i * 3);
        m_dm[0] = 32'd7;
        m_dm[1] = 32'hFFFF_FFFD;
        m_im[0]  = enc_i(6'd35, 0, 1, 16'd0);
        m_im[1]  = enc_i(6'd35, 0, 2, 16'd4);
        m_im[2]  = enc_r(1, 2, 3, 6'd32);
        m_im[3]  = enc_r(2, 1, 4, 6'd34);
        m_im[4]  = enc_r(1, 2, 5, 6'd36);
        m_im[5]  = enc_r(1, 2, 6, 6'd37);
        m_im[6]  = enc_r(2, 1, 7, 6'd42);
        m_im[7]  = enc_r(1, 2, 8, 6'd42);
        m_im[8]  = enc_r(1, 1, 0, 6'd32);
        m_im[9]  = enc_i(6'd43, 0, 3, 16'd8);
        m_im[10] = enc_i(6'd35, 0, 9, 16'd8);
        m_im[11] = enc_i(6'd4, 1, 2, 16'd5);
        m_im[12] = enc_i(6'd4, 1, 1, 16'd2);
        m_im[13] = enc_r(1, 1, 10, 6'd32);
        m_im[14] = enc_r(1, 1, 11, 6'd32);
        m_im[16] = {6'd2, 26'd20};
        m_im[17] = enc_r(1, 1, 12, 6'd32);
        m_im[20] = enc_i(6'd35, 0, 0, 16'd4);
        m_im[21] = enc_i(6'd4, 0, 0, 16'hFFFF);
        start_phase();
        run_cycles(30);
    endtask

    // Pseudo-random program drawn densely from low registers.
    task automatic random_phase(input logic [31:0] seed, input int n);
        lcg = seed;
        for (int i = 0; i < DW; i++) m_dm[i] = rnd();
        for (int i = 0; i < IW; i++) begin
            logic [31:0] r;
            int k, s, t, d;
            r = rnd();
            k = int'(r[31:28]) % 11;
            s = int'(r[2:0]); t = int'(r[5:3]); d = int'(r[8:6]);
            case (k)
                0: m_im[i] = enc_r(s, t, d, 6'd32);
                1: m_im[i] = enc_r(s, t, d, 6'd34);
                2: m_im[i] = enc_r(s, t, d, 6'd36);
                3: m_im[i] = enc_r(s, t, d, 6'd37);
                4: m_im[i] = enc_r(s, t, d, 6'd42);
                5, 6: m_im[i] = enc_i(6'd35, s, t, rnd()[15:0]);
                7: m_im[i] = enc_i(6'd43, s, t, rnd()[15:0]);
                8: m_im[i] = enc_i(6'd4, s, t, {{12{r[12]}}, r[12:9]});
                9: m_im[i] = {6'd2, rnd()[25:0]};
                default: m_im[i] = {6'd63, r[25:0]};
            endcase
        end
        start_phase();
        run_cycles(n);
    endtask

    // Watchdog: a hung run counts as a failure and still prints the summary.
    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            n_checks++;
            n_errors++;
            $display("FAIL watchdog: actual=timeout expected=completion");
            $display("  Result: errors=%0d of %0d checks", n_errors, n_checks);
            $finish;
        end
    end

    initial begin
        directed();
        random_phase(32'h1234_5678, 400);
        random_phase(32'hCAFE_0001, 400);
        random_phase(32'h0BAD_F00D, 400);
        random_phase(32'h7777_0042, 400);
        done = 1'b1;
        $display("  Result: errors=%0d of %0d checks", n_errors, n_checks);
        $finish;
    end
endmodule